// File: doc/BRIEF.md
# Compound Frame Descriptor Walker

This block takes in, one entry at a time, the frame entries that together describe a single offload job and works out the role of each entry. An entry carries a length, a 40-bit address given as a high byte and a low word, and a final flag. The role of an entry depends on its position in the job and on the job's operation code. Position 0 is always the command block. The next one or two positions are destinations: a copy or a weighted XOR has one destination, and a dual-parity job has two. Every later entry is a source, and the source that carries the final flag ends the job.

The walker keeps the command-block pointer and length, the destination addresses, the common data length and the number of sources. It writes each source address into a small memory that can be read back by index. A job that completes raises a one-cycle done pulse. A job that breaks a rule raises a one-cycle error pulse with a reason code. Once a job has failed, the walker discards the entries that follow until it sees a final flag, so the next job is framed correctly. Reading descriptors from memory and computing on the data belong to other blocks.

Top module: `frame_walker`

## Requirements
- R1: After a synchronous reset, `done`, `err`, `err_code` and `src_count` are all 0, and the next valid entry is taken as position 0 of a new job.
- R2: The entry at position 0 is latched as the command block: `cmd_addr` = {high byte, low word} and `cmd_len` = its length. `job_op` is sampled in the same cycle. Its encoding is 0 copy, 1 weighted XOR, 2 dual parity, 3 reserved.
- R3: A copy or XOR job has its one destination at position 1, and `dst_count` = 1. A dual-parity job has its destinations at positions 1 and 2 (`dst0_addr`, `dst1_addr`), and `dst_count` = 2.
- R4: Sources are stored in arrival order at indices 0, 1, and so on. `src_rd_addr` shows the address stored at `src_rd_idx` one clock after the index is applied. `src_count` is the number of sources accepted so far in the job.
- R5: When a final entry in a source position is accepted with no error, `done` is high for exactly one cycle after that clock edge. `job_len` then equals the length of the first destination. All job outputs hold until the next job's position-0 entry is accepted.
- R6: A final flag on the command-block entry or on a destination entry ends the job with `err` and `err_code` = 1.
- R7: A length above MAX_LEN (1,048,576) on any entry gives `err_code` = 2. A length of exactly MAX_LEN is accepted.
- R8: A second destination or a source whose length differs from the first destination's length gives `err_code` = 3.
- R9: An entry at position MAX_ENTRIES-1 (position 18, the 19th entry) that has no final flag gives `err_code` = 4.
- R10: A copy job whose first source has no final flag gives `err_code` = 5. A reserved opcode at position 0 gives `err_code` = 6.
- R11: After an error on an entry without the final flag, entries up to and including the next final entry are discarded and change no output. After an error on a final entry, the next entry starts a new job.
- R12: When one entry breaks several rules, a single code is reported, in this order of precedence: reserved opcode, length limit, length mismatch, early final, extra copy source, too many entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | 1 | An entry is present this cycle |
| ent_len | input | LEN_W (24) | Entry length field |
| ent_addr_hi | input | HI_W (8) | Upper address byte |
| ent_addr_lo | input | LO_W (32) | Lower address word |
| ent_final | input | 1 | Entry is the last of the job |
| job_op | input | 2 | Operation code, sampled with position 0 |
| src_rd_idx | input | IDX_W (5) | Source list read index |
| cmd_addr | output | ADDR_W (40) | Command block address |
| cmd_len | output | LEN_W (24) | Command block length |
| dst0_addr | output | ADDR_W (40) | First destination address |
| dst1_addr | output | ADDR_W (40) | Second destination address (dual parity) |
| dst_count | output | 2 | Number of destinations for the job |
| job_len | output | LEN_W (24) | Common data length of the job |
| src_count | output | CNT_W (5) | Sources accepted in the job |
| src_rd_addr | output | ADDR_W (40) | Source address at `src_rd_idx`, one cycle later |
| done | output | 1 | One-cycle pulse: job complete |
| err | output | 1 | One-cycle pulse: job aborted |
| err_code | output | 3 | Reason for the latest abort |

## Verification
The main function is swept over every legal source count for each opcode: one source for a copy, 1 to 17 for XOR and 1 to 16 for dual parity. Each job uses its own addresses and lengths, so a wrong slot, a source stored out of order or a miscounted destination shows up as a mismatch. Lengths of exactly the limit and one above it separate the accepting boundary from the rejecting one. Jobs that break one rule, and jobs that break two rules at once, separate the error codes and their precedence. Entries sent after an error, both with and without a final flag, show whether discarding stops at the right point and whether the next job is framed from position 0.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_XOR  = 2'd1,
    OP_DUAL = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    E_NONE   = 3'd0,
    E_EARLY  = 3'd1,
    E_LEN    = 3'd2,
    E_MISM   = 3'd3,
    E_MANY   = 3'd4,
    E_COPYX  = 3'd5,
    E_BADOP  = 3'd6
  } err_e;

  typedef enum logic [1:0] {
    RL_CMD = 2'd0,
    RL_DST = 2'd1,
    RL_SRC = 2'd2
  } role_e;

endpackage

// File: rtl/fw_classify.sv
module fw_classify
  import fw_pkg::*;
#(
  parameter int LEN_W       = 24,
  parameter int ENT_W       = 5,
  parameter int MAX_LEN     = 1048576,
  parameter int MAX_ENTRIES = 19
) (
  input  logic [ENT_W-1:0] pos,
  input  op_e              op,
  input  logic [LEN_W-1:0] len,
  input  logic             fin,
  input  logic [LEN_W-1:0] ref_len,
  output role_e            role,
  output err_e             code
);

  localparam logic [LEN_W-1:0] LIM  = LEN_W'(MAX_LEN);
  localparam logic [ENT_W-1:0] LAST = ENT_W'(MAX_ENTRIES - 1);

  logic [ENT_W-1:0] ndst;
  logic             over, mism;

  always_comb begin
    ndst = (op == OP_DUAL) ? ENT_W'(2) : ENT_W'(1);
    if (pos == '0)         role = RL_CMD;
    else if (pos <= ndst)  role = RL_DST;
    else                   role = RL_SRC;

    over = (len > LIM);
    mism = (pos > ENT_W'(1)) && (len != ref_len);

    // precedence order is part of the behaviour
    if (role == RL_CMD && op == OP_RSVD)                      code = E_BADOP;
    else if (over)                                            code = E_LEN;
    else if (mism)                                            code = E_MISM;
    else if (fin && role != RL_SRC)                           code = E_EARLY;
    else if (role == RL_SRC && op == OP_COPY && !fin)         code = E_COPYX;
    else if (role == RL_SRC && !fin && pos == LAST)           code = E_MANY;
    else                                                      code = E_NONE;
  end

endmodule

// File: rtl/fw_src_ram.sv
module fw_src_ram #(
  parameter int DW    = 40,
  parameter int DEPTH = 17,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/frame_walker.sv
module frame_walker
  import fw_pkg::*;
#(
  parameter  int HI_W        = 8,
  parameter  int LO_W        = 32,
  parameter  int LEN_W       = 24,
  parameter  int MAX_LEN     = 1048576,
  parameter  int MAX_ENTRIES = 19,
  localparam int ADDR_W      = HI_W + LO_W,
  localparam int SRC_DEPTH   = MAX_ENTRIES - 2,
  localparam int IDX_W       = $clog2(SRC_DEPTH),
  localparam int CNT_W       = $clog2(SRC_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_valid,
  input  logic [LEN_W-1:0]  ent_len,
  input  logic [HI_W-1:0]   ent_addr_hi,
  input  logic [LO_W-1:0]   ent_addr_lo,
  input  logic              ent_final,
  input  logic [1:0]        job_op,
  input  logic [IDX_W-1:0]  src_rd_idx,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [ADDR_W-1:0] dst0_addr,
  output logic [ADDR_W-1:0] dst1_addr,
  output logic [1:0]        dst_count,
  output logic [LEN_W-1:0]  job_len,
  output logic [CNT_W-1:0]  src_count,
  output logic [ADDR_W-1:0] src_rd_addr,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code
);

  localparam int ENT_W = $clog2(MAX_ENTRIES);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_LEN);

  typedef enum logic [1:0] {S_IDLE, S_BODY, S_DRAIN} st_e;

  st_e              st;
  logic [ENT_W-1:0] pos_q, pos_cur;
  op_e              op_q, op_cur;
  logic [LEN_W-1:0] ref_q;
  role_e            role;
  err_e             code;
  logic [ADDR_W-1:0] addr_in;
  logic             wr_en;

  assign addr_in = {ent_addr_hi, ent_addr_lo};
  assign op_cur  = (st == S_IDLE) ? op_e'(job_op) : op_q;
  assign pos_cur = (st == S_IDLE) ? '0 : pos_q;

  fw_classify #(
    .LEN_W(LEN_W), .ENT_W(ENT_W), .MAX_LEN(MAX_LEN), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_cls (
    .pos(pos_cur), .op(op_cur), .len(ent_len), .fin(ent_final),
    .ref_len(ref_q), .role(role), .code(code)
  );

  assign wr_en = ent_valid && (st == S_BODY) && (role == RL_SRC) && (code == E_NONE);

  fw_src_ram #(.DW(ADDR_W), .DEPTH(SRC_DEPTH), .AW(IDX_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(src_count[IDX_W-1:0]), .wdata(addr_in),
    .raddr(src_rd_idx), .rdata(src_rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pos_q     <= '0;
      op_q      <= OP_COPY;
      ref_q     <= '0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      dst0_addr <= '0;
      dst1_addr <= '0;
      dst_count <= '0;
      job_len   <= '0;
      src_count <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (ent_valid) begin
        case (st)
          S_IDLE: begin
            if (code != E_NONE) begin
              err      <= 1'b1;
              err_code <= code;
              st       <= ent_final ? S_IDLE : S_DRAIN;
            end else begin
              cmd_addr  <= addr_in;
              cmd_len   <= ent_len;
              op_q      <= op_cur;
              dst_count <= (op_cur == OP_DUAL) ? 2'd2 : 2'd1;
              dst0_addr <= '0;
              dst1_addr <= '0;
              job_len   <= '0;
              ref_q     <= '0;
              src_count <= '0;
              pos_q     <= ENT_W'(1);
              st        <= S_BODY;
            end
          end
          S_BODY: begin
            if (code != E_NONE) begin
              err      <= 1'b1;
              err_code <= code;
              st       <= ent_final ? S_IDLE : S_DRAIN;
            end else begin
              pos_q <= pos_q + ENT_W'(1);
              if (role == RL_DST) begin
                if (pos_q == ENT_W'(1)) begin
                  dst0_addr <= addr_in;
                  ref_q     <= ent_len;
                  job_len   <= ent_len;
                end else begin
                  dst1_addr <= addr_in;
                end
              end else begin
                src_count <= src_count + CNT_W'(1);
                if (ent_final) begin
                  done <= 1'b1;
                  st   <= S_IDLE;
                end
              end
            end
          end
          S_DRAIN: begin
            if (ent_final) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R5
  AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(ent_valid && ent_final)); // R5
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    err |-> err_code != 3'd0); // R6
  AST_DONE_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    done |-> job_len <= LIM); // R7
  AST_SRC_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    src_count <= CNT_W'(SRC_DEPTH)); // R9
  AST_COPY_ONE_SRC: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_COPY) |-> src_count == CNT_W'(1)); // R10
  AST_DUAL_TWO_DST: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_DUAL) |-> dst_count == 2'd2); // R3
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == S_DRAIN) |=> ($stable(src_count) && $stable(cmd_addr))); // R11

endmodule

// File: tb/frame_walker_test.sv
module frame_walker_test;

  localparam int MAXL = 1048576;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ent_valid = 1'b0;
  logic [23:0] ent_len = '0;
  logic [7:0]  ent_addr_hi = '0;
  logic [31:0] ent_addr_lo = '0;
  logic        ent_final = 1'b0;
  logic [1:0]  job_op = '0;
  logic [4:0]  src_rd_idx = '0;
  logic [39:0] cmd_addr, dst0_addr, dst1_addr, src_rd_addr;
  logic [23:0] cmd_len, job_len;
  logic [1:0]  dst_count;
  logic [4:0]  src_count;
  logic        done, err;
  logic [2:0]  err_code;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame_walker uut (
    .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_len(ent_len),
    .ent_addr_hi(ent_addr_hi), .ent_addr_lo(ent_addr_lo), .ent_final(ent_final),
    .job_op(job_op), .src_rd_idx(src_rd_idx), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .dst0_addr(dst0_addr), .dst1_addr(dst1_addr), .dst_count(dst_count),
    .job_len(job_len), .src_count(src_count), .src_rd_addr(src_rd_addr),
    .done(done), .err(err), .err_code(err_code)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mk(input int seed, input int k);
    return {8'(seed), 32'(k * 4096 + seed * 16 + 4)};
  endfunction

  task automatic put(input int len, input logic [39:0] a, input bit fin, input int op);
    @(negedge clk);
    ent_valid   = 1'b1;
    ent_len     = 24'(len);
    ent_addr_hi = a[39:32];
    ent_addr_lo = a[31:0];
    ent_final   = fin;
    job_op      = 2'(op);
  endtask

  task automatic gap();
    @(negedge clk);
    ent_valid = 1'b0;
    ent_final = 1'b0;
  endtask

  task automatic expect_err(input int code, input string req);
    gap();
    chk(err, 1, req);
    chk(err_code, 64'(code), req);
    chk(done, 0, req);
  endtask

  task automatic run_good(input int op, input int nsrc, input int len, input int seed);
    int nd;
    nd = (op == 2) ? 2 : 1;
    put(32 + seed, mk(seed, 0), 0, op);
    for (int d = 0; d < nd; d++) put(len, mk(seed, 1 + d), 0, op);
    for (int s = 0; s < nsrc; s++) put(len, mk(seed, 8 + s), s == nsrc - 1, op);
    gap();
    chk(done, 1, "R5 done pulse");
    chk(err, 0, "R5 no err");
    chk(cmd_addr, mk(seed, 0), "R2 cmd_addr");
    chk(cmd_len, 64'(32 + seed), "R2 cmd_len");
    chk(dst_count, 64'(nd), "R3 dst_count");
    chk(dst0_addr, mk(seed, 1), "R3 dst0");
    if (nd == 2) chk(dst1_addr, mk(seed, 2), "R3 dst1");
    chk(job_len, 64'(len), "R5 job_len");
    chk(src_count, 64'(nsrc), "R4 src_count");
    @(negedge clk);
    chk(done, 0, "R5 single pulse");
    for (int s = 0; s < nsrc; s++) begin
      src_rd_idx = 5'(s);
      @(negedge clk);
      chk(src_rd_addr, mk(seed, 8 + s), "R4 source order");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done, 0, "R1 done");
    chk(err, 0, "R1 err");
    chk(err_code, 0, "R1 err_code");
    chk(src_count, 0, "R1 src_count");

    // sweep of every legal source count per opcode
    run_good(0, 1, 4096, 1);
    for (int n = 1; n <= 17; n++) run_good(1, n, (n * 40961) % (MAXL + 1), 10 + n);
    for (int n = 1; n <= 16; n++) run_good(2, n, (n * 65537 + 7) % (MAXL + 1), 40 + n);
    run_good(1, 3, MAXL, 70); // R7 boundary accepted

    // R6: final on command entry, then final on second destination
    put(16, mk(80, 0), 1, 1);
    expect_err(1, "R6 final on cmd");
    put(16, mk(81, 0), 0, 2);
    put(100, mk(81, 1), 0, 2);
    put(100, mk(81, 2), 1, 2);
    expect_err(1, "R6 final on dst1");
    run_good(1, 2, 500, 82);

    // R7: one above limit on a source and on the command block
    put(16, mk(83, 0), 0, 1);
    put(MAXL, mk(83, 1), 0, 1);
    put(MAXL + 1, mk(83, 8), 1, 1);
    expect_err(2, "R7 over limit on source");
    put(MAXL + 1, mk(84, 0), 1, 0);
    expect_err(2, "R7 over limit on cmd");

    // R8: mismatch on a source and on second destination
    put(16, mk(85, 0), 0, 1);
    put(300, mk(85, 1), 0, 1);
    put(300, mk(85, 8), 0, 1);
    put(301, mk(85, 9), 1, 1);
    expect_err(3, "R8 source mismatch");
    put(16, mk(86, 0), 0, 2);
    put(300, mk(86, 1), 0, 2);
    put(299, mk(86, 2), 0, 2);
    expect_err(3, "R8 dst1 mismatch");
    put(300, mk(86, 8), 1, 2); // drained
    gap();
    chk(done, 0, "R11 drained final no done");

    // R12: mismatch with final on dst reports mismatch; over limit beats mismatch
    put(16, mk(87, 0), 0, 2);
    put(100, mk(87, 1), 0, 2);
    put(200, mk(87, 2), 1, 2);
    expect_err(3, "R12 mismatch over early final");
    put(16, mk(88, 0), 0, 1);
    put(100, mk(88, 1), 0, 1);
    put(MAXL + 5, mk(88, 8), 1, 1);
    expect_err(2, "R12 length over mismatch");
    put(MAXL + 5, mk(89, 0), 0, 3);
    expect_err(6, "R12 bad op over length");
    put(7, mk(89, 1), 1, 3);
    gap();

    // R9: nineteen entries without final
    put(16, mk(90, 0), 0, 1);
    put(64, mk(90, 1), 0, 1);
    for (int s = 0; s < 16; s++) put(64, mk(90, 8 + s), 0, 1);
    gap();
    chk(err, 0, "R9 no error before limit");
    chk(src_count, 16, "R9 sixteen sources held");
    put(64, mk(90, 30), 0, 1);
    expect_err(4, "R9 too many entries");

    // R11: entries after error change nothing until final
    put(64, mk(91, 0), 0, 0);
    put(64, mk(91, 1), 0, 2);
    gap();
    chk(cmd_addr, mk(90, 0), "R11 cmd_addr held in drain");
    chk(src_count, 16, "R11 src_count held in drain");
    chk(err, 0, "R11 no err in drain");
    put(64, mk(91, 2), 1, 1);
    gap();
    chk(done, 0, "R11 no done at drained final");
    chk(cmd_addr, mk(90, 0), "R11 cmd_addr after drain");
    run_good(2, 2, 777, 92);

    // R10: copy with extra source, reserved opcode
    put(16, mk(93, 0), 0, 0);
    put(50, mk(93, 1), 0, 0);
    put(50, mk(93, 8), 0, 0);
    expect_err(5, "R10 copy extra source");
    put(50, mk(93, 9), 1, 0);
    gap();
    chk(done, 0, "R11 copy tail drained");
    put(16, mk(94, 0), 1, 3);
    expect_err(6, "R10 reserved opcode");
    run_good(0, 1, 50, 95); // R11 new job framed right after error on final

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule